// File: doc/BRIEF.md
# Binary Floating-Point Multiplier

The block multiplies two binary floating-point words. Each word has a sign bit at the top, a biased exponent field below it and a fraction field in the low bits. With the default parameters (8-bit exponent, 23-bit fraction) this is the common 32-bit single-precision layout: sign in bit 31, exponent in bits 30:23 with a bias of 127, and fraction in bits 22:0. A normal operand has a hidden leading one in front of its fraction.

The work is split over two register stages. The first stage classifies each operand as zero, infinity, NaN or ordinary. Denormal operands are treated as zero. The same stage forms the result sign, adds the exponents and takes off one bias, and multiplies the two significands as unsigned magnitudes. The second stage normalises the product and rounds it to nearest, ties to even. It then decides overflow or underflow from the final exponent and packs the result word.

Operations are accepted on any cycle that the input valid is high. Each result appears two cycles later with its own valid, and results leave in the order they arrived.

Top module: `fp_mul_top`

## Requirements
- R1: For two normal operands, the result is the exact product rounded to the nearest representable value, with sign bit at the top, exponent bias 2^(EXP_W-1)-1 and a hidden leading one.
- R2: The sign of every non-NaN result is the XOR of the two operand signs.
- R3: Rounding is to nearest with ties to even. When rounding carries out of the significand, the fraction becomes zero and the exponent goes up by one.
- R4: When either operand is a NaN (exponent all ones, fraction nonzero), the result is the quiet NaN. The quiet NaN has sign 0, exponent all ones and only the fraction MSB set (0x7FC00000 at default size). Both flags stay low.
- R5: Zero (or denormal) times infinity returns the quiet NaN with both flags low.
- R6: Infinity times a nonzero value or times infinity returns infinity with the XOR sign and both flags low.
- R7: Zero times a finite value returns signed zero with both flags low. An operand with a zero exponent field counts as zero, whatever its fraction.
- R8: If the final biased exponent is all ones or larger, the result is signed infinity and the overflow flag is 1. A final exponent of all ones minus one is returned as a normal value.
- R9: If the final biased exponent is 0 or below, the result is signed zero and the underflow flag is 1. A final exponent of 1 is returned as a normal value.
- R10: out_valid is high exactly two cycles after each cycle with in_valid high and at no other time. Results leave in input order.
- R11: While rst_n is low, out_valid, out_res, out_ovf and out_unf are all 0.
- R12: out_ovf and out_unf are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on in_a and in_b are to be multiplied |
| in_a | input | 1+EXP_W+FRAC_W | First operand |
| in_b | input | 1+EXP_W+FRAC_W | Second operand |
| out_valid | output | 1 | out_res and flags hold a result |
| out_res | output | 1+EXP_W+FRAC_W | Rounded product |
| out_ovf | output | 1 | Result exponent too large; result is signed infinity |
| out_unf | output | 1 | Result exponent too small; result is signed zero |

## Verification
The assertions assume that in_valid is held low for the whole time rst_n is low. The two-cycle valid checks look back across the reset edge and depend on this. The sign check relates the output to the operands two cycles earlier, so it also assumes operands are known whenever in_valid is high. The bench drives known zeros before and during reset, and it changes inputs only on falling clock edges. It sweeps every operand pair of a reduced format (4-bit exponent, 3-bit fraction), with idle cycles mixed in. It then runs directed cases on a default-size instance, aimed at rounding ties and the exponent limits.

// File: rtl/fp_mul_pkg.sv
package fp_mul_pkg;

  typedef enum logic [1:0] {
    CLS_NUM  = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_cls_e;

  // Result category from the two operand categories.
  function automatic fp_cls_e merge_cls(input fp_cls_e a, input fp_cls_e b);
    if (a == CLS_NAN || b == CLS_NAN)
      return CLS_NAN;
    if ((a == CLS_INF && b == CLS_ZERO) || (a == CLS_ZERO && b == CLS_INF))
      return CLS_NAN;
    if (a == CLS_INF || b == CLS_INF)
      return CLS_INF;
    if (a == CLS_ZERO || b == CLS_ZERO)
      return CLS_ZERO;
    return CLS_NUM;
  endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fp_mul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      expo,
  output logic [FRAC_W:0]       sig,
  output fp_cls_e               cls
);
  logic [FRAC_W-1:0] frac;
  logic              exp_zero;
  logic              exp_full;

  assign sign     = word[EXP_W+FRAC_W];
  assign expo     = word[EXP_W+FRAC_W-1:FRAC_W];
  assign frac     = word[FRAC_W-1:0];
  assign exp_zero = (expo == '0);
  assign exp_full = &expo;
  assign sig      = {~exp_zero, frac};

  always_comb begin
    if (exp_full)
      cls = (frac != '0) ? CLS_NAN : CLS_INF;
    else if (exp_zero)
      cls = CLS_ZERO;   // denormals are flushed
    else
      cls = CLS_NUM;
  end
endmodule

// File: rtl/fpm_sig_mult.sv
module fpm_sig_mult #(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W-1:0]   a,
  input  logic [SIG_W-1:0]   b,
  output logic [2*SIG_W-1:0] prod
);
  assign prod = (2*SIG_W)'(a) * (2*SIG_W)'(b);
endmodule

// File: rtl/fpm_pack.sv
module fpm_pack
  import fp_mul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_v,
  input  logic                        sign,
  input  fp_cls_e                     cls,
  input  logic signed [EXP_W+1:0]     esum,
  input  logic [2*FRAC_W+1:0]         prod,
  output logic                        out_v,
  output logic [EXP_W+FRAC_W:0]       res,
  output logic                        ovf,
  output logic                        unf
);
  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int S    = FRAC_W + 1;
  localparam int PW   = 2 * S;
  localparam int XW   = EXP_W + 2;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // Internal events, named for the checks below.
  logic                 norm_top;
  logic [PW-1:0]        norm;
  logic signed [XW-1:0] e_norm;
  logic [S-1:0]         kept;
  logic                 g_bit, r_bit, s_bit;
  logic                 rnd_up;
  logic [S:0]           rnd_sum;
  logic                 rnd_carry;
  logic [S-1:0]         sig_fin;
  logic signed [XW-1:0] e_fin;
  logic                 ovf_c, unf_c;
  logic [W-1:0]         res_c;

  assign norm_top  = prod[PW-1];
  assign norm      = norm_top ? prod : (prod << 1);
  assign e_norm    = esum + $signed({{(XW-1){1'b0}}, norm_top});
  assign kept      = norm[PW-1 -: S];
  assign g_bit     = norm[S-1];
  assign r_bit     = norm[S-2];
  assign s_bit     = |norm[S-3:0];
  assign rnd_up    = g_bit & (r_bit | s_bit | kept[0]);
  assign rnd_sum   = {1'b0, kept} + {{S{1'b0}}, rnd_up};
  assign rnd_carry = rnd_sum[S];
  assign sig_fin   = rnd_carry ? rnd_sum[S:1] : rnd_sum[S-1:0];
  assign e_fin     = e_norm + $signed({{(XW-1){1'b0}}, rnd_carry});
  assign ovf_c     = (cls == CLS_NUM) && (e_fin >= $signed(XW'(EMAX)));
  assign unf_c     = (cls == CLS_NUM) && (e_fin <= $signed(XW'(0)));

  always_comb begin
    unique case (cls)
      CLS_NAN:  res_c = QNAN;
      CLS_INF:  res_c = {sign, INF_MAG};
      CLS_ZERO: res_c = {sign, {(W-1){1'b0}}};
      default: begin
        if (ovf_c)      res_c = {sign, INF_MAG};
        else if (unf_c) res_c = {sign, {(W-1){1'b0}}};
        else            res_c = {sign, e_fin[EXP_W-1:0], sig_fin[FRAC_W-1:0]};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      res   <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        res <= res_c;
        ovf <= ovf_c;
        unf <= unf_c;
      end
    end
  end

  // R3
  rnd_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && cls == CLS_NUM && rnd_carry && !ovf_c && !unf_c)
      |=> (res[FRAC_W-1:0] == '0));
  // R8
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (res[W-2:0] == INF_MAG));
  // R9
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (res[W-2:0] == '0));
  // R12
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
  // R4
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && (&res[W-2:FRAC_W]) && (res[FRAC_W-1:0] != '0)) |-> (res == QNAN));
endmodule

// File: rtl/fp_mul_top.sv
module fp_mul_top
  import fp_mul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] in_a,
  input  logic [EXP_W+FRAC_W:0] in_b,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] out_res,
  output logic                  out_ovf,
  output logic                  out_unf
);
  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int S    = FRAC_W + 1;
  localparam int PW   = 2 * S;
  localparam int XW   = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [W-1:0]     op_w   [2];
  logic             op_s   [2];
  logic [EXP_W-1:0] op_e   [2];
  logic [S-1:0]     op_sig [2];
  fp_cls_e          op_c   [2];

  assign op_w[0] = in_a;
  assign op_w[1] = in_b;

  for (genvar i = 0; i < 2; i++) begin : g_op
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .word (op_w[i]),
      .sign (op_s[i]),
      .expo (op_e[i]),
      .sig  (op_sig[i]),
      .cls  (op_c[i])
    );
  end

  logic [PW-1:0]        prod_c;
  logic signed [XW-1:0] esum_c;

  fpm_sig_mult #(.SIG_W(S)) u_mult (
    .a    (op_sig[0]),
    .b    (op_sig[1]),
    .prod (prod_c)
  );

  assign esum_c = $signed({2'b00, op_e[0]}) + $signed({2'b00, op_e[1]})
                - $signed(XW'(BIAS));

  // Stage 1 registers
  logic                 s1_valid;
  logic                 s1_sign;
  fp_cls_e              s1_cls;
  logic signed [XW-1:0] s1_esum;
  logic [PW-1:0]        s1_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_cls   <= CLS_ZERO;
      s1_esum  <= '0;
      s1_prod  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sign <= op_s[0] ^ op_s[1];
        s1_cls  <= merge_cls(op_c[0], op_c[1]);
        s1_esum <= esum_c;
        s1_prod <= prod_c;
      end
    end
  end

  fpm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (s1_valid),
    .sign  (s1_sign),
    .cls   (s1_cls),
    .esum  (s1_esum),
    .prod  (s1_prod),
    .out_v (out_valid),
    .res   (out_res),
    .ovf   (out_ovf),
    .unf   (out_unf)
  );

  // R10
  v_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  // R10
  v_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_valid));
  // R2
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !((&out_res[W-2:FRAC_W]) && (out_res[FRAC_W-1:0] != '0)))
      |-> (out_res[W-1] == ($past(in_a[W-1], 2) ^ $past(in_b[W-1], 2))));
endmodule

// File: tb/fp_mul_top_bench.sv
module fp_mul_top_bench;
  localparam int SE = 4;
  localparam int SF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // Reduced-format instance
  logic       s_valid = 1'b0;
  logic [7:0] s_a = '0, s_b = '0;
  logic       s_ov;
  logic [7:0] s_res;
  logic       s_ovf, s_unf;

  // Default-size instance
  logic        d_valid = 1'b0;
  logic [31:0] d_a = '0, d_b = '0;
  logic        d_ov;
  logic [31:0] d_res;
  logic        d_ovf, d_unf;

  fp_mul_top #(.EXP_W(SE), .FRAC_W(SF)) u_fp_mul_top_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_a(s_a), .in_b(s_b),
    .out_valid(s_ov), .out_res(s_res), .out_ovf(s_ovf), .out_unf(s_unf));

  fp_mul_top u_fp_mul_top (
    .clk(clk), .rst_n(rst_n), .in_valid(d_valid), .in_a(d_a), .in_b(d_b),
    .out_valid(d_ov), .out_res(d_res), .out_ovf(d_ovf), .out_unf(d_unf));

  int  tests = 0;
  int  fails = 0;
  bit  done  = 1'b0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [33:0] act, input logic [33:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Reference for the reduced format: bias 7, exact integer product,
  // rounded by comparing the discarded remainder with half a unit.
  task automatic ref_small(input logic [7:0] a, input logic [7:0] b,
                           output logic [9:0] r, output string tag);
    int ea, eb, fa, fb, ma, mb, p, msb, sh, kept, rem, half, e;
    logic sg;
    bit za, zb, ia, ib, na, nb;
    ea = int'(a[6:3]); eb = int'(b[6:3]);
    fa = int'(a[2:0]); fb = int'(b[2:0]);
    sg = a[7] ^ b[7];
    na = (ea == 15) && (fa != 0); nb = (eb == 15) && (fb != 0);
    ia = (ea == 15) && (fa == 0); ib = (eb == 15) && (fb == 0);
    za = (ea == 0); zb = (eb == 0);
    if (na || nb) begin r = {2'b00, 8'h7C}; tag = "R4"; return; end
    if ((ia && zb) || (ib && za)) begin r = {2'b00, 8'h7C}; tag = "R5"; return; end
    if (ia || ib) begin r = {2'b00, sg, 7'h78}; tag = "R6"; return; end
    if (za || zb) begin r = {2'b00, sg, 7'h00}; tag = "R7"; return; end
    ma = 8 + fa; mb = 8 + fb;
    p = ma * mb;
    msb = (p >= 128) ? 7 : 6;
    sh = msb - 3;
    kept = p >> sh;
    rem  = p - (kept << sh);
    half = 1 << (sh - 1);
    if (rem > half || (rem == half && (kept % 2) == 1)) kept++;
    e = ea + eb - 7 + (msb - 6);
    if (kept == 16) begin kept = 8; e++; end
    if (e >= 15) begin r = {2'b10, sg, 7'h78}; tag = "R8"; end
    else if (e <= 0) begin r = {2'b01, sg, 7'h00}; tag = "R9"; end
    else begin r = {2'b00, sg, 4'(e), 3'(kept - 8)}; tag = "R1"; end
  endtask

  task automatic pop_check();
    logic [9:0] ev;
    string t;
    if (s_ov) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected out_valid", 34'(s_res), 34'd0);
      end else begin
        ev = exp_q.pop_front();
        t  = tag_q.pop_front();
        chk({s_ovf, s_unf, s_res} == ev, t, "small product {ovf,unf,res}",
            34'({s_ovf, s_unf, s_res}), 34'(ev));
      end
    end
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] er, input logic eo, input logic eu,
                       input string req);
    @(negedge clk);
    d_valid = 1'b1; d_a = a; d_b = b;
    @(negedge clk);
    d_valid = 1'b0;
    chk(!d_ov, "R10", "valid one cycle early", 34'(d_ov), 34'd0);
    @(negedge clk);
    chk(d_ov, "R10", "valid after two cycles", 34'(d_ov), 34'd1);
    chk({d_ovf, d_unf, d_res} == {eo, eu, er}, req, "fp32 product {ovf,unf,res}",
        {d_ovf, d_unf, d_res}, {eo, eu, er});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({s_ov, s_ovf, s_unf, s_res} == '0, "R11", "small outputs in reset",
        34'({s_ov, s_ovf, s_unf, s_res}), 34'd0);
    chk({d_ov, d_ovf, d_unf} == '0 && d_res == '0, "R11", "fp32 outputs in reset",
        34'({d_ov, d_ovf, d_unf, d_res}), 34'd0);
    rst_n = 1'b1;

    // Exhaustive sweep of the reduced format (R1, R4..R10, R12 via flags)
    for (int i = 0; i < 65536; i++) begin
      logic [9:0] ev;
      string t;
      @(negedge clk);
      pop_check();
      s_valid = 1'b1;
      s_a = 8'(i >> 8);
      s_b = 8'(i);
      ref_small(s_a, s_b, ev, t);
      exp_q.push_back(ev);
      tag_q.push_back(t);
      if (i % 11 == 0) begin
        @(negedge clk);
        pop_check();
        s_valid = 1'b0;
      end
    end
    @(negedge clk);
    pop_check();
    s_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pop_check();
    end
    chk(exp_q.size() == 0, "R10", "results outstanding", 34'(exp_q.size()), 34'd0);

    // Directed cases on the default-size instance
    run32(32'h3FC00000, 32'h40000000, 32'h40400000, 1'b0, 1'b0, "R1");
    run32(32'hBFC00000, 32'h40000000, 32'hC0400000, 1'b0, 1'b0, "R2");
    run32(32'h3F800001, 32'h3F800001, 32'h3F800002, 1'b0, 1'b0, "R3");
    run32(32'h3FC00000, 32'h3F800001, 32'h3FC00002, 1'b0, 1'b0, "R3");
    run32(32'h7F800001, 32'h3F800000, 32'h7FC00000, 1'b0, 1'b0, "R4");
    run32(32'h00000000, 32'hFF800000, 32'h7FC00000, 1'b0, 1'b0, "R5");
    run32(32'hFF800000, 32'h3F800000, 32'hFF800000, 1'b0, 1'b0, "R6");
    run32(32'h7F800000, 32'h7F800000, 32'h7F800000, 1'b0, 1'b0, "R6");
    run32(32'h80000001, 32'h3F800000, 32'h80000000, 1'b0, 1'b0, "R7");
    run32(32'h7F000000, 32'h40000000, 32'h7F800000, 1'b1, 1'b0, "R8");
    run32(32'h7F000000, 32'h3F800000, 32'h7F000000, 1'b0, 1'b0, "R8");
    run32(32'h00800000, 32'h3F000000, 32'h00000000, 1'b0, 1'b1, "R9");
    run32(32'h00800000, 32'h3F800000, 32'h00800000, 1'b0, 1'b0, "R9");
    run32(32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 1'b0, 1'b0, "R1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule